// File: doc/BRIEF.md
# Configurable True Dual-Port Block Memory

This block is a synchronous memory with two fully independent access ports, A and B. Each port has its own clock, synchronous output reset, enable, per-byte write strobes, address, write data and read data. The ports share nothing but the stored words. Every access is taken on a rising edge of the port's own clock. The read data register keeps its value until the port's next enabled cycle.

Each port is tuned by parameters:
- A write-mode parameter decides what the read data shows during a write: the old word, the newly stored word, or its previous value.
- An optional output pipeline register adds one cycle of read latency for a shorter clock-to-output path.
- A split parameter turns the array into two independent half-depth memories. Each half then has its own A and B lanes. Every port signal becomes a two-lane vector, with lane 0 in the low slice.

Two ports can write the same word on the same edge. Port A then wins the bytes that both ports enable. Port B's other bytes are still written. A read on one port of a word the other port writes on the same edge returns the contents from before that edge. These collision rules assume both ports are clocked by the same clock edge.

Top module: `dpram_tdp`

## Requirements
- R1: An active synchronous port reset (`*_rst` = 1) clears that port's read data register to zero on the next edge. When the pipeline stage is present, it clears that register too. The read data of the port is then 0.
- R2: A cycle with enable = 1 and all write strobes 0 is a read. The addressed word appears on the read data one edge later without the pipeline stage.
- R3: A write is an enabled cycle with at least one write strobe set. Strobe bit i updates only data bits [8i+7:8i]. Bytes with a clear strobe keep their stored value.
- R4: In mode `WM_READ_FIRST` (0), the read data after a write holds the word as it was before that write.
- R5: In mode `WM_WRITE_FIRST` (1), the read data after a write holds the stored word with this port's written bytes replaced by its write data.
- R6: In mode `WM_NO_CHANGE` (2), the read data keeps its previous value across a write.
- R7: With enable = 0, a port neither reads nor writes. Its read data and pipeline register hold their values.
- R8: With the pipeline parameter set and enable held at 1, the read data for an access appears one edge later than without it. That is two edges after the access.
- R9: When both ports write the same address on the same edge, bytes enabled on both take port A's data. Bytes enabled only on B take port B's data.
- R10: A read of an address that the other port writes on the same edge returns the contents from before that edge.
- R11: With the split parameter set, the two halves are independent. The same lane-local address in each half holds separate data.
- R12: A port reset does not change the stored contents. A read after reset returns the data written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | LANES | Port A clock per lane (LANES = 2 when split, else 1) |
| a_rst | input | LANES | Port A synchronous output reset per lane |
| a_en | input | LANES | Port A enable per lane |
| a_we | input | LANES*NUM_BYTES | Port A byte write strobes |
| a_addr | input | LANES*AW | Port A word address (AW = log2 of words per lane) |
| a_din | input | LANES*DATA_W | Port A write data |
| a_dout | output | LANES*DATA_W | Port A read data |
| b_clk | input | LANES | Port B clock per lane |
| b_rst | input | LANES | Port B synchronous output reset per lane |
| b_en | input | LANES | Port B enable per lane |
| b_we | input | LANES*NUM_BYTES | Port B byte write strobes |
| b_addr | input | LANES*AW | Port B word address |
| b_din | input | LANES*DATA_W | Port B write data |
| b_dout | output | LANES*DATA_W | Port B read data |

## Verification
The bench sends both ports at a small address window so that same-word collisions happen often.

Each collision targets a specific failure:
- A design that let port B win, or that dropped B's bytes outside A's strobes, corrupts the word under R9.
- A design that forwarded the other port's same-edge write would return new data where R10 expects old data.
- Holding enable low while strobes and address keep changing exposes a design that writes or reloads its output regardless of enable.
- A pipeline stage that advanced on idle cycles, or skipped a cycle, shifts the port B read data by one access.

On the split instance, writes to one half would show up in the other if the halves aliased. A no-change port that reloaded on a write would show the new word where R6 expects the old one.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Behaviour of a port's read data during a write cycle
    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

endpackage

// File: rtl/dpram_bank.sv
// Storage for one memory bank. Each port owns one array, and a word is
// the XOR of both. A port writes (data ^ other array), so neither array
// is ever driven from two clock domains.
module dpram_bank #(
    parameter int DATA_W    = 32,
    parameter int NUM_BYTES = 4,
    parameter int DEPTH     = 512,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic                 a_clk,
    input  logic                 a_rst,
    input  logic                 a_en,
    input  logic [NUM_BYTES-1:0] a_we,
    input  logic [AW-1:0]        a_addr,
    input  logic [DATA_W-1:0]    a_din,
    output logic [DATA_W-1:0]    a_old,
    output logic [NUM_BYTES-1:0] a_be_eff,
    input  logic                 b_clk,
    input  logic                 b_rst,
    input  logic                 b_en,
    input  logic [NUM_BYTES-1:0] b_we,
    input  logic [AW-1:0]        b_addr,
    input  logic [DATA_W-1:0]    b_din,
    output logic [DATA_W-1:0]    b_old,
    output logic [NUM_BYTES-1:0] b_be_eff
);
    localparam int BW = DATA_W / NUM_BYTES;

    logic [DATA_W-1:0] store_a [DEPTH];
    logic [DATA_W-1:0] store_b [DEPTH];

    logic [NUM_BYTES-1:0] a_claim;
    logic [DATA_W-1:0]    a_mask;
    logic [DATA_W-1:0]    b_mask;

    function automatic logic [DATA_W-1:0] expand(input logic [NUM_BYTES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < NUM_BYTES; i++) begin
            m[i*BW +: BW] = {BW{be[i]}};
        end
        return m;
    endfunction

    // Contents seen by each port before this edge (R10: old data)
    assign a_old = store_a[a_addr] ^ store_b[a_addr];
    assign b_old = store_a[b_addr] ^ store_b[b_addr];

    // Port A priority on a same-word collision (R9)
    assign a_claim  = (a_en && (a_addr == b_addr)) ? a_we : '0;
    assign a_be_eff = a_en ? a_we : '0;
    assign b_be_eff = b_en ? (b_we & ~a_claim) : '0;
    assign a_mask   = expand(a_be_eff);
    assign b_mask   = expand(b_be_eff);

    always_ff @(posedge a_clk) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (a_be_eff[i]) begin
                store_a[a_addr][i*BW +: BW] <= a_din[i*BW +: BW] ^ store_b[a_addr][i*BW +: BW];
            end
        end
    end

    always_ff @(posedge b_clk) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (b_be_eff[i]) begin
                store_b[b_addr][i*BW +: BW] <= b_din[i*BW +: BW] ^ store_a[b_addr][i*BW +: BW];
            end
        end
    end

    // The two checks below assume both ports share one clock edge.
    // R3 / R9: bytes written by A hold A's data after the edge
    p_a_write_lands_r3: assert property (@(posedge a_clk) disable iff (a_rst)
        (|a_be_eff) |=> (((store_a[$past(a_addr)] ^ store_b[$past(a_addr)]) & $past(a_mask))
                         == ($past(a_din) & $past(a_mask))));

    // R9: bytes left to B after arbitration hold B's data after the edge
    p_b_write_lands_r9: assert property (@(posedge b_clk) disable iff (b_rst)
        (|b_be_eff) |=> (((store_a[$past(b_addr)] ^ store_b[$past(b_addr)]) & $past(b_mask))
                         == ($past(b_din) & $past(b_mask))));

endmodule

// File: rtl/dpram_port.sv
// Read data register, write-mode selection and optional pipeline for one port
module dpram_port
    import dpram_pkg::*;
#(
    parameter int     DATA_W    = 32,
    parameter int     NUM_BYTES = 4,
    parameter wmode_e MODE      = WM_READ_FIRST,
    parameter bit     PIPE      = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 we_any,
    input  logic [NUM_BYTES-1:0] be_eff,
    input  logic [DATA_W-1:0]    din,
    input  logic [DATA_W-1:0]    old_word,
    output logic [DATA_W-1:0]    dout
);
    localparam int BW = DATA_W / NUM_BYTES;

    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] wr_view;

    // The stored word as this port's own write leaves it
    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            merged[i*BW +: BW] = be_eff[i] ? din[i*BW +: BW] : old_word[i*BW +: BW];
        end
    end

    always_comb begin
        unique case (MODE)
            WM_READ_FIRST:  wr_view = old_word;
            WM_WRITE_FIRST: wr_view = merged;
            WM_NO_CHANGE:   wr_view = out_q;
            default:        wr_view = old_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (en) begin
            out_q <= we_any ? wr_view : old_word;
        end
    end

    generate
        if (PIPE) begin : g_pipe
            logic [DATA_W-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe_q <= '0;
                end else if (en) begin
                    pipe_q <= out_q;
                end
            end
            assign dout = pipe_q;

            // R8: the pipeline stage takes the previous register value
            p_pipe_delay_r8: assert property (@(posedge clk) disable iff (rst)
                en |=> (pipe_q == $past(out_q)));
            // R7: the pipeline stage holds while idle
            p_pipe_hold_r7: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(pipe_q));
        end else begin : g_direct
            assign dout = out_q;
        end

        if (MODE == WM_NO_CHANGE) begin : g_nc_chk
            // R6: a write leaves the read data untouched
            p_no_change_r6: assert property (@(posedge clk) disable iff (rst)
                (en && we_any) |=> $stable(out_q));
        end
        if (MODE == WM_READ_FIRST) begin : g_rf_chk
            // R4: a write shows the old word
            p_read_first_r4: assert property (@(posedge clk) disable iff (rst)
                (en && we_any) |=> (out_q == $past(old_word)));
        end
        if (MODE == WM_WRITE_FIRST) begin : g_wf_chk
            // R5: the written bytes appear at once
            p_write_first_r5: assert property (@(posedge clk) disable iff (rst)
                (en && we_any) |=> (out_q == $past(merged)));
        end
    endgenerate

    // R2: a plain read loads the addressed word
    p_read_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !we_any) |=> (out_q == $past(old_word)));

    // R7: an idle port keeps its register
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_q));

endmodule

// File: rtl/dpram_tdp.sv
module dpram_tdp
    import dpram_pkg::*;
#(
    parameter int     DATA_W    = 32,
    parameter int     NUM_BYTES = 4,
    parameter int     DEPTH     = 512,
    parameter int     SPLIT     = 0,
    parameter wmode_e A_MODE    = WM_READ_FIRST,
    parameter wmode_e B_MODE    = WM_WRITE_FIRST,
    parameter bit     A_PIPE    = 1'b0,
    parameter bit     B_PIPE    = 1'b1
) (
    input  logic [((SPLIT != 0) ? 2 : 1)-1:0]                                    a_clk,
    input  logic [((SPLIT != 0) ? 2 : 1)-1:0]                                    a_rst,
    input  logic [((SPLIT != 0) ? 2 : 1)-1:0]                                    a_en,
    input  logic [((SPLIT != 0) ? 2 : 1)*NUM_BYTES-1:0]                          a_we,
    input  logic [((SPLIT != 0) ? 2 : 1)*$clog2(DEPTH/((SPLIT != 0) ? 2 : 1))-1:0] a_addr,
    input  logic [((SPLIT != 0) ? 2 : 1)*DATA_W-1:0]                             a_din,
    output logic [((SPLIT != 0) ? 2 : 1)*DATA_W-1:0]                             a_dout,
    input  logic [((SPLIT != 0) ? 2 : 1)-1:0]                                    b_clk,
    input  logic [((SPLIT != 0) ? 2 : 1)-1:0]                                    b_rst,
    input  logic [((SPLIT != 0) ? 2 : 1)-1:0]                                    b_en,
    input  logic [((SPLIT != 0) ? 2 : 1)*NUM_BYTES-1:0]                          b_we,
    input  logic [((SPLIT != 0) ? 2 : 1)*$clog2(DEPTH/((SPLIT != 0) ? 2 : 1))-1:0] b_addr,
    input  logic [((SPLIT != 0) ? 2 : 1)*DATA_W-1:0]                             b_din,
    output logic [((SPLIT != 0) ? 2 : 1)*DATA_W-1:0]                             b_dout
);
    localparam int LANES      = (SPLIT != 0) ? 2 : 1;
    localparam int BANK_DEPTH = DEPTH / LANES;
    localparam int BAW        = $clog2(BANK_DEPTH);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [DATA_W-1:0]    a_old_w;
            logic [DATA_W-1:0]    b_old_w;
            logic [NUM_BYTES-1:0] a_be_w;
            logic [NUM_BYTES-1:0] b_be_w;

            dpram_bank #(
                .DATA_W    (DATA_W),
                .NUM_BYTES (NUM_BYTES),
                .DEPTH     (BANK_DEPTH),
                .AW        (BAW)
            ) u_bank (
                .a_clk    (a_clk[g]),
                .a_rst    (a_rst[g]),
                .a_en     (a_en[g]),
                .a_we     (a_we[g*NUM_BYTES +: NUM_BYTES]),
                .a_addr   (a_addr[g*BAW +: BAW]),
                .a_din    (a_din[g*DATA_W +: DATA_W]),
                .a_old    (a_old_w),
                .a_be_eff (a_be_w),
                .b_clk    (b_clk[g]),
                .b_rst    (b_rst[g]),
                .b_en     (b_en[g]),
                .b_we     (b_we[g*NUM_BYTES +: NUM_BYTES]),
                .b_addr   (b_addr[g*BAW +: BAW]),
                .b_din    (b_din[g*DATA_W +: DATA_W]),
                .b_old    (b_old_w),
                .b_be_eff (b_be_w)
            );

            dpram_port #(
                .DATA_W    (DATA_W),
                .NUM_BYTES (NUM_BYTES),
                .MODE      (A_MODE),
                .PIPE      (A_PIPE)
            ) u_port_a (
                .clk      (a_clk[g]),
                .rst      (a_rst[g]),
                .en       (a_en[g]),
                .we_any   (|a_we[g*NUM_BYTES +: NUM_BYTES]),
                .be_eff   (a_be_w),
                .din      (a_din[g*DATA_W +: DATA_W]),
                .old_word (a_old_w),
                .dout     (a_dout[g*DATA_W +: DATA_W])
            );

            dpram_port #(
                .DATA_W    (DATA_W),
                .NUM_BYTES (NUM_BYTES),
                .MODE      (B_MODE),
                .PIPE      (B_PIPE)
            ) u_port_b (
                .clk      (b_clk[g]),
                .rst      (b_rst[g]),
                .en       (b_en[g]),
                .we_any   (|b_we[g*NUM_BYTES +: NUM_BYTES]),
                .be_eff   (b_be_w),
                .din      (b_din[g*DATA_W +: DATA_W]),
                .old_word (b_old_w),
                .dout     (b_dout[g*DATA_W +: DATA_W])
            );
        end
    endgenerate

endmodule

// File: tb/dpram_tdp_bench.sv
`timescale 1ns/1ps
module dpram_tdp_bench;
    import dpram_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // ---------------- main instance: A read-first, B write-first + pipe
    logic        a_rst, a_en, b_rst, b_en;
    logic [3:0]  a_we, b_we;
    logic [8:0]  a_addr, b_addr;
    logic [31:0] a_din, b_din, a_dout, b_dout;

    dpram_tdp u_dpram_tdp (
        .a_clk(clk), .a_rst(a_rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .a_din(a_din), .a_dout(a_dout),
        .b_clk(clk), .b_rst(b_rst), .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .b_din(b_din), .b_dout(b_dout)
    );

    // ---------------- split instance: A no-change, B read-first, no pipes
    logic [1:0]  s_a_rst, s_a_en, s_b_rst, s_b_en;
    logic [7:0]  s_a_we, s_b_we;
    logic [15:0] s_a_addr, s_b_addr;
    logic [63:0] s_a_din, s_b_din, s_a_dout, s_b_dout;

    dpram_tdp #(
        .SPLIT(1), .A_MODE(WM_NO_CHANGE), .B_MODE(WM_READ_FIRST),
        .A_PIPE(1'b0), .B_PIPE(1'b0)
    ) u_dpram_tdp_split (
        .a_clk({clk, clk}), .a_rst(s_a_rst), .a_en(s_a_en), .a_we(s_a_we),
        .a_addr(s_a_addr), .a_din(s_a_din), .a_dout(s_a_dout),
        .b_clk({clk, clk}), .b_rst(s_b_rst), .b_en(s_b_en), .b_we(s_b_we),
        .b_addr(s_b_addr), .b_din(s_b_din), .b_dout(s_b_dout)
    );

    // ---------------- reference model
    logic [31:0] model [512];
    logic [31:0] ea, eb_reg, eb_pipe;

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : old[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] init_word(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_main();
        a_rst = 0; a_en = 0; a_we = 0; a_addr = 0; a_din = 0;
        b_rst = 0; b_en = 0; b_we = 0; b_addr = 0; b_din = 0;
    endtask

    // One clock on the main instance: predict, clock, compare
    task automatic cyc(input string tag, input bit chk);
        logic [31:0] oa, ob, nb, na_e, nr, np;
        logic [3:0]  beff;
        oa   = model[a_addr];
        ob   = model[b_addr];
        beff = b_en ? (b_we & ~((a_en && a_addr == b_addr) ? a_we : 4'h0)) : 4'h0;
        na_e = a_rst ? 32'h0 : (a_en ? oa : ea);
        nb   = (b_en && b_we != 4'h0) ? merge(ob, b_din, beff) : ob;
        np   = b_rst ? 32'h0 : (b_en ? eb_reg : eb_pipe);
        nr   = b_rst ? 32'h0 : (b_en ? nb : eb_reg);
        if (a_en) model[a_addr] = merge(model[a_addr], a_din, a_we);
        if (b_en) model[b_addr] = merge(model[b_addr], b_din, beff);
        ea = na_e; eb_reg = nr; eb_pipe = np;
        @(posedge clk);
        @(negedge clk);
        if (chk) begin
            check({tag, " port A"}, {32'h0, a_dout}, {32'h0, ea});
            check({tag, " port B"}, {32'h0, b_dout}, {32'h0, eb_pipe});
        end
    endtask

    task automatic scyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // ---------------- watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_main();
        s_a_rst = 0; s_a_en = 0; s_a_we = 0; s_a_addr = 0; s_a_din = 0;
        s_b_rst = 0; s_b_en = 0; s_b_we = 0; s_b_addr = 0; s_b_din = 0;
        for (int i = 0; i < 512; i++) model[i] = 32'h0;
        ea = 0; eb_reg = 0; eb_pipe = 0;
        @(negedge clk);

        // R1: reset clears read data and pipeline
        a_rst = 1; b_rst = 1; a_en = 1; b_en = 1; b_addr = 9'd1;
        cyc("R1 reset", 1'b0);
        cyc("R1 reset", 1'b0);
        check("R1 port A after reset", {32'h0, a_dout}, 64'h0);
        check("R1 port B after reset", {32'h0, b_dout}, 64'h0);
        idle_main();

        // fill addresses 0..15 with known words, outputs not compared
        for (int i = 0; i < 16; i++) begin
            a_en = 1; a_we = 4'hF; a_addr = 9'(i); a_din = init_word(i);
            cyc("fill", 1'b0);
        end
        idle_main();
        a_rst = 1; b_rst = 1; a_en = 1; b_en = 1;
        cyc("R1 reset after fill", 1'b0);
        cyc("R1 reset after fill", 1'b1);
        idle_main();

        // R2 plain read (A) and R8 pipelined read (B)
        a_en = 1; a_addr = 9'd3; b_en = 1; b_addr = 9'd4;
        cyc("R2 R8 read", 1'b1);
        check("R2 port A word 3", {32'h0, a_dout}, {32'h0, init_word(3)});
        check("R8 port B not yet", {32'h0, b_dout}, 64'h0);
        cyc("R2 R8 read", 1'b1);
        check("R8 port B word 4 after two edges", {32'h0, b_dout}, {32'h0, init_word(4)});
        idle_main();

        // R3 byte mask then R4 read-first view
        a_en = 1; a_we = 4'b0101; a_addr = 9'd2; a_din = 32'hFFFF_FFFF;
        cyc("R3 R4 masked write", 1'b1);
        check("R4 port A shows old word", {32'h0, a_dout}, {32'h0, init_word(2)});
        a_we = 0;
        cyc("R3 read back", 1'b1);
        check("R3 masked bytes", {32'h0, a_dout},
              {32'h0, merge(init_word(2), 32'hFFFF_FFFF, 4'b0101)});
        idle_main();

        // R5 write-first on B with pipe
        b_en = 1; b_we = 4'b1100; b_addr = 9'd6; b_din = 32'hDEAD_BEEF;
        cyc("R5 write-first", 1'b1);
        b_we = 0; b_addr = 9'd5;
        cyc("R5 write-first", 1'b1);
        check("R5 port B merged word", {32'h0, b_dout},
              {32'h0, merge(init_word(6), 32'hDEAD_BEEF, 4'b1100)});
        idle_main();

        // R7 idle with active-looking controls: nothing written, outputs held
        for (int k = 0; k < 4; k++) begin
            a_en = 0; a_we = 4'hF; a_addr = 9'd2; a_din = 32'h0;
            b_en = 0; b_we = 4'hF; b_addr = 9'd6; b_din = 32'h0;
            cyc("R7 idle hold", 1'b1);
        end
        idle_main();
        a_en = 1; a_addr = 9'd2;
        cyc("R7 no write while idle", 1'b1);
        check("R7 word 2 intact", {32'h0, a_dout},
              {32'h0, merge(init_word(2), 32'hFFFF_FFFF, 4'b0101)});
        idle_main();

        // R9 same-word write collision
        a_en = 1; a_we = 4'b0011; a_addr = 9'd7; a_din = 32'h1111_1111;
        b_en = 1; b_we = 4'b0110; b_addr = 9'd7; b_din = 32'h2222_2222;
        cyc("R9 collision", 1'b1);
        idle_main();
        a_en = 1; a_addr = 9'd7;
        cyc("R9 read back", 1'b1);
        check("R9 A wins shared byte", {32'h0, a_dout},
              {32'h0, init_word(7)[31:24], 8'h22, 8'h11, 8'h11});
        idle_main();

        // R10 B reads a word A writes on the same edge
        a_en = 1; a_we = 4'hF; a_addr = 9'd8; a_din = 32'h3333_3333;
        b_en = 1; b_addr = 9'd8;
        cyc("R10 cross read", 1'b1);
        a_en = 0; a_we = 0; b_addr = 9'd9;
        cyc("R10 cross read", 1'b1);
        check("R10 B sees old word", {32'h0, b_dout}, {32'h0, init_word(8)});
        idle_main();

        // R12 reset keeps contents
        a_rst = 1; b_rst = 1;
        cyc("R12 reset", 1'b1);
        idle_main();
        a_en = 1; a_addr = 9'd8;
        cyc("R12 read after reset", 1'b1);
        check("R12 word 8 kept", {32'h0, a_dout}, {32'h0, 32'h3333_3333});
        idle_main();

        // random mix over a small window (R2 R3 R4 R5 R7 R8 R9 R10 R1)
        void'($urandom(32'd12345));
        for (int n = 0; n < 400; n++) begin
            a_rst  = ($urandom % 40) == 0;
            b_rst  = ($urandom % 40) == 0;
            a_en   = ($urandom % 4) != 0;
            b_en   = ($urandom % 4) != 0;
            a_we   = ($urandom % 2) ? 4'($urandom) : 4'h0;
            b_we   = ($urandom % 2) ? 4'($urandom) : 4'h0;
            a_addr = 9'($urandom % 8);
            b_addr = 9'($urandom % 8);
            a_din  = $urandom;
            b_din  = $urandom;
            cyc("random R3 R4 R5 R9 R10", 1'b1);
        end
        idle_main();

        // ---------------- split instance
        s_a_rst = 2'b11; s_b_rst = 2'b11;
        scyc();
        check("R1 split reset", {s_a_dout[31:0], s_b_dout[31:0]}, 64'h0);
        s_a_rst = 0; s_b_rst = 0;

        s_a_en = 2'b11; s_a_we = 8'hFF; s_a_addr = {8'd10, 8'd10};
        s_a_din = {32'hBBBB_1111, 32'hAAAA_0000};
        scyc();
        check("R6 no-change after write", s_a_dout, 64'h0);
        s_a_en = 0; s_a_we = 0;

        s_b_en = 2'b11; s_b_addr = {8'd10, 8'd10};
        scyc();
        check("R11 halves independent", s_b_dout, {32'hBBBB_1111, 32'hAAAA_0000});
        s_b_en = 0;

        s_a_en = 2'b01; s_a_addr = {8'd0, 8'd10};
        scyc();
        check("R2 split read", {32'h0, s_a_dout[31:0]}, {32'h0, 32'hAAAA_0000});

        s_a_we = 8'h0F; s_a_addr = {8'd0, 8'd11}; s_a_din = {32'h0, 32'h0000_5555};
        scyc();
        check("R6 held across write", {32'h0, s_a_dout[31:0]}, {32'h0, 32'hAAAA_0000});
        s_a_en = 0; s_a_we = 0;

        s_b_en = 2'b01; s_b_addr = {8'd11, 8'd11};
        scyc();
        check("R11 lane0 word 11", {32'h0, s_b_dout[31:0]}, {32'h0, 32'h0000_5555});
        check("R7 lane1 idle holds", {32'h0, s_b_dout[63:32]}, {32'h0, 32'hBBBB_1111});
        s_b_en = 0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule